// File: doc/BRIEF.md
# Shifted-Operand Compare Unit

This unit performs the flag-setting part of a register-to-register compare on 32-bit data. The second operand first goes through an immediate shifter: logical left, logical right, arithmetic right, rotate right, or a one-bit rotate that pulls the incoming carry flag in at the top. The shifted value is then subtracted from the first operand. The subtraction is done as the first operand plus the bitwise inverse of the shifted value plus one. The difference itself is dropped. Only the four condition flags (negative, zero, carry, overflow) leave the block, together with a strobe that marks when they are to be written.

Operand fetch, condition evaluation and instruction decode sit upstream. The block receives the operands, a 2-bit shift type, an already decoded shift amount of up to 63, a rotate-with-extend select, the current carry flag and a condition-pass bit. The parameter `FLAG_REG` selects the output form:
- `FLAG_REG = 1` (the default): the block holds the flags in its own register. That register is written only on passing cycles and keeps its value otherwise.
- `FLAG_REG = 0`: the flags are combinational, and the strobe leaves the write decision to the consumer.

Top module: `shcmp_unit`

## Requirements
- R1: `sh_type_i` selects the shift: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. Rotate right turns by `sh_amt_i` modulo 32, so an amount of 32 leaves the operand unchanged.
- R2: When `rrx_i` is 1, the second operand is shifted right by one and `carry_i` enters at bit 31. `sh_type_i` and `sh_amt_i` are ignored in this case.
- R3: For amounts of 32 or more, logical right and logical left give zero, and arithmetic right gives 32 copies of operand bit 31.
- R4: With `rrx_i` = 0 and `sh_amt_i` = 0, every shift type passes the second operand through unchanged.
- R5: N is bit 31 of `op_a_i + ~shifted + 1`. Z is 1 exactly when all 32 bits of that sum are zero.
- R6: C is the carry out of bit 31 of that sum. It is 1 exactly when `op_a_i` >= shifted value as unsigned numbers. `carry_i` has no effect on C except through the rotate-with-extend path.
- R7: V is 1 when `op_a_i` and `~shifted` have equal bit 31 and the sum's bit 31 differs from it.
- R8: `flags_o` packs the flags as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R9: With `FLAG_REG` = 1:
  - Reset clears `flags_o` and `flags_we_o`.
  - The edge after a cycle with `cond_pass_i` = 1 loads the new flags and raises `flags_we_o` for one cycle.
  - After a cycle with `cond_pass_i` = 0, the flags keep their previous value and `flags_we_o` is 0.
- R10: With `FLAG_REG` = 0, `flags_o` follows the same-cycle inputs and `flags_we_o` equals `cond_pass_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 32 | First operand (minuend) |
| op_b_i | input | 32 | Second operand, shifted before the subtraction |
| sh_type_i | input | 2 | Shift type code |
| sh_amt_i | input | 6 | Decoded shift amount, 0 to 63 |
| rrx_i | input | 1 | Rotate-with-extend select |
| carry_i | input | 1 | Current carry flag, used by rotate-with-extend |
| cond_pass_i | input | 1 | Condition passed; enables the flag write |
| flags_o | output | 4 | Flags {N, Z, C, V} |
| flags_we_o | output | 1 | Flag write strobe |

## Verification
The bench builds two copies, both with `DATA_W` = 32: the default `FLAG_REG` = 1 and a second with `FLAG_REG` = 0. The registered copy covers the reset value, the one-cycle load latency and flag holding across failing cycles. The combinational copy is compared in the same cycle as the stimulus, which checks the shifter and adder without the register in the path. Together with a 6-bit amount field, this 32-bit width lets amounts of exactly 32 and above be driven, which exercises the saturating logical shifts, sign fill and full-turn rotation.

// File: rtl/shcmp_pkg.sv
package shcmp_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } sh_kind_e;

    // Flag order R8: {N, Z, C, V}
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        nzcv_t flags;
        logic  we;
    } flag_state_t;

endpackage

// File: rtl/shcmp_shifter.sv
module shcmp_shifter
    import shcmp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0]  val_i,
    input  logic [1:0]         kind_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               rrx_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  val_o
);
    localparam int ROT_W = $clog2(DATA_W);
    localparam logic [SHAMT_W-1:0] AMT_FULL = SHAMT_W'(DATA_W);

    logic [ROT_W-1:0]    rot_amt;
    logic [2*DATA_W-1:0] rot_dbl;
    logic                big_amt;

    assign rot_amt = amt_i[ROT_W-1:0];
    assign rot_dbl = {val_i, val_i} >> rot_amt;
    assign big_amt = (amt_i >= AMT_FULL);

    always_comb begin
        val_o = val_i;
        if (rrx_i) begin
            val_o = {carry_i, val_i[DATA_W-1:1]};
        end else begin
            unique case (sh_kind_e'(kind_i))
                SH_LSL:  val_o = big_amt ? '0 : (val_i << amt_i);
                SH_LSR:  val_o = big_amt ? '0 : (val_i >> amt_i);
                SH_ASR:  val_o = big_amt ? {DATA_W{val_i[DATA_W-1]}}
                                         : DATA_W'($signed(val_i) >>> amt_i);
                SH_ROR:  val_o = rot_dbl[DATA_W-1:0];
                default: val_o = val_i;
            endcase
        end
    end

endmodule

// File: rtl/shcmp_flagcalc.sv
module shcmp_flagcalc
    import shcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output nzcv_t             flags_o
);
    logic [DATA_W-1:0] rhs_inv;
    logic [DATA_W:0]   sum;

    assign rhs_inv = ~rhs_i;
    assign sum     = {1'b0, lhs_i} + {1'b0, rhs_inv} + {{DATA_W{1'b0}}, 1'b1};

    always_comb begin
        flags_o.n = sum[DATA_W-1];
        flags_o.z = (sum[DATA_W-1:0] == '0);
        flags_o.c = sum[DATA_W];
        flags_o.v = (lhs_i[DATA_W-1] == rhs_inv[DATA_W-1]) &&
                    (sum[DATA_W-1] != lhs_i[DATA_W-1]);
    end

endmodule

// File: rtl/shcmp_unit.sv
module shcmp_unit
    import shcmp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit FLAG_REG = 1'b1,
    parameter int SHAMT_W  = $clog2(DATA_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  op_a_i,
    input  logic [DATA_W-1:0]  op_b_i,
    input  logic [1:0]         sh_type_i,
    input  logic [SHAMT_W-1:0] sh_amt_i,
    input  logic               rrx_i,
    input  logic               carry_i,
    input  logic               cond_pass_i,
    output logic [3:0]         flags_o,
    output logic               flags_we_o
);
    logic [DATA_W-1:0] shifted;
    nzcv_t             new_flags;

    shcmp_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .val_i   (op_b_i),
        .kind_i  (sh_type_i),
        .amt_i   (sh_amt_i),
        .rrx_i   (rrx_i),
        .carry_i (carry_i),
        .val_o   (shifted)
    );

    shcmp_flagcalc #(.DATA_W(DATA_W)) u_calc (
        .lhs_i   (op_a_i),
        .rhs_i   (shifted),
        .flags_o (new_flags)
    );

    generate
        if (FLAG_REG) begin : g_reg
            flag_state_t state_d, state_q;

            always_comb begin
                state_d    = state_q;
                state_d.we = cond_pass_i;
                if (cond_pass_i) begin
                    state_d.flags = new_flags;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= '0;
                end else begin
                    state_q <= state_d;
                end
            end

            assign flags_o    = state_q.flags;
            assign flags_we_o = state_q.we;
        end else begin : g_comb
            assign flags_o    = new_flags;
            assign flags_we_o = cond_pass_i;
        end
    endgenerate

endmodule

// File: rtl/shcmp_chk.sv
module shcmp_chk #(
    parameter int DATA_W   = 32,
    parameter bit FLAG_REG = 1'b1,
    parameter int SHAMT_W  = $clog2(DATA_W) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  op_a_i,
    input logic [DATA_W-1:0]  op_b_i,
    input logic [1:0]         sh_type_i,
    input logic [SHAMT_W-1:0] sh_amt_i,
    input logic               rrx_i,
    input logic               carry_i,
    input logic               cond_pass_i,
    input logic [3:0]         flags_o,
    input logic               flags_we_o
);
    localparam logic [SHAMT_W-1:0] AMT_FULL = SHAMT_W'(DATA_W);

    generate
        if (FLAG_REG) begin : g_reg_chk
            p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !cond_pass_i |=> ($stable(flags_o) && !flags_we_o));

            p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
                cond_pass_i |=> flags_we_o);

            // equal operands, no shift: Z and C set, N and V clear
            p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_pass_i && !rrx_i && sh_amt_i == '0 && op_a_i == op_b_i)
                |=> (flags_o == 4'b0110));

            // unsigned lower with pass-through operand gives borrow
            p_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_pass_i && !rrx_i && sh_amt_i == '0 && op_a_i < op_b_i)
                |=> !flags_o[1]);

            // logical right by the full width subtracts zero
            p_lsr_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_pass_i && !rrx_i && sh_type_i == 2'b01 && sh_amt_i >= AMT_FULL)
                |=> (flags_o[1] && !flags_o[0] && (flags_o[2] == ($past(op_a_i) == '0))));

            p_zn_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
                flags_o[2] |-> !flags_o[3]);
        end else begin : g_comb_chk
            p_strobe_comb_r10: assert property (@(posedge clk) disable iff (!rst_n)
                flags_we_o == cond_pass_i);

            p_zn_excl_comb_r5: assert property (@(posedge clk) disable iff (!rst_n)
                flags_o[2] |-> !flags_o[3]);
        end
    endgenerate

endmodule

bind shcmp_unit shcmp_chk #(
    .DATA_W   (DATA_W),
    .FLAG_REG (FLAG_REG),
    .SHAMT_W  (SHAMT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_a_i      (op_a_i),
    .op_b_i      (op_b_i),
    .sh_type_i   (sh_type_i),
    .sh_amt_i    (sh_amt_i),
    .rrx_i       (rrx_i),
    .carry_i     (carry_i),
    .cond_pass_i (cond_pass_i),
    .flags_o     (flags_o),
    .flags_we_o  (flags_we_o)
);

// File: tb/shcmp_unit_bench.sv
module shcmp_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  sh_type = '0;
    logic [5:0]  sh_amt = '0;
    logic        rrx = 1'b0;
    logic        carry = 1'b0;
    logic        cond = 1'b0;
    logic [3:0]  flags_r, flags_c;
    logic        we_r, we_c;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [3:0] flags;
        logic       we;
        string      tag;
    } exp_item_t;

    exp_item_t   sb_q[$];
    logic [3:0]  held_flags = 4'b0000;

    always #2 clk = ~clk;

    shcmp_unit #(.DATA_W(32), .FLAG_REG(1'b1)) u_shcmp_unit (
        .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
        .sh_type_i(sh_type), .sh_amt_i(sh_amt), .rrx_i(rrx), .carry_i(carry),
        .cond_pass_i(cond), .flags_o(flags_r), .flags_we_o(we_r)
    );

    shcmp_unit #(.DATA_W(32), .FLAG_REG(1'b0)) u_shcmp_unit_comb (
        .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
        .sh_type_i(sh_type), .sh_amt_i(sh_amt), .rrx_i(rrx), .carry_i(carry),
        .cond_pass_i(cond), .flags_o(flags_c), .flags_we_o(we_c)
    );

    // bit-serial reference shifter
    function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
                                              input logic [5:0] n, input logic x, input logic ci);
        logic [31:0] r;
        r = v;
        if (x) return {ci, v[31:1]};
        case (k)
            2'b00: for (int i = 0; i < int'(n); i++) r = {r[30:0], 1'b0};
            2'b01: for (int i = 0; i < int'(n); i++) r = {1'b0, r[31:1]};
            2'b10: for (int i = 0; i < int'(n); i++) r = {r[31], r[31:1]};
            default: for (int i = 0; i < int'(n) % 32; i++) r = {r[0], r[31:1]};
        endcase
        return r;
    endfunction

    // reference flags {N,Z,C,V} from a true subtraction
    function automatic logic [3:0] ref_flags(input logic [31:0] a, input logic [31:0] s);
        logic [31:0] d;
        logic n, z, c, v;
        d = a - s;
        n = d[31];
        z = (d == 32'd0);
        c = (a >= s);
        v = (a[31] != s[31]) && (d[31] != a[31]);
        return {n, z, c, v};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] k,
                         input logic [5:0] n, input logic x, input logic ci,
                         input logic cp, input string tag);
        logic [3:0] f;
        exp_item_t  it;
        @(negedge clk);
        op_a = a; op_b = b; sh_type = k; sh_amt = n; rrx = x; carry = ci; cond = cp;
        f = ref_flags(a, ref_shift(b, k, n, x, ci));
        if (cp) held_flags = f;
        it.flags = held_flags; it.we = cp; it.tag = tag;
        sb_q.push_back(it);
        #1;
        checks++;
        if (flags_c !== f || we_c !== cp) begin
            failures++;
            $display("FAIL %s R10 comb: flags=%b we=%b expected flags=%b we=%b",
                     tag, flags_c, we_c, f, cp);
        end
    endtask

    // monitor: registered output after the edge that follows each drive
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t e;
            e = sb_q.pop_front();
            checks++;
            if (flags_r !== e.flags || we_r !== e.we) begin
                failures++;
                $display("FAIL %s reg: flags=%b we=%b expected flags=%b we=%b",
                         e.tag, flags_r, we_r, e.flags, e.we);
            end
        end
    end

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        checks++;
        if (flags_r !== 4'b0000 || we_r !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset: flags=%b we=%b expected flags=0000 we=0", flags_r, we_r);
        end
        rst_n = 1'b1;

        drive(32'd5, 32'd5, 2'b00, 6'd0, 1'b0, 1'b0, 1'b1, "R4_R8 equal");
        drive(32'd3, 32'd5, 2'b11, 6'd0, 1'b0, 1'b0, 1'b1, "R6 borrow");
        drive(32'h7fffffff, 32'hffffffff, 2'b01, 6'd0, 1'b0, 1'b0, 1'b1, "R7 ovf_pos");
        drive(32'h80000000, 32'd1, 2'b10, 6'd0, 1'b0, 1'b0, 1'b1, "R7 ovf_neg");
        drive(32'd16, 32'd1, 2'b00, 6'd4, 1'b0, 1'b0, 1'b1, "R1 lsl4");
        drive(32'd0, 32'hffffffff, 2'b01, 6'd32, 1'b0, 1'b0, 1'b1, "R3 lsr32");
        drive(32'hffffffff, 32'h80000000, 2'b10, 6'd32, 1'b0, 1'b0, 1'b1, "R3 asr32");
        drive(32'd7, 32'hffffffff, 2'b00, 6'd40, 1'b0, 1'b1, 1'b1, "R3 lsl40");
        drive(32'hab000000, 32'h000000ab, 2'b11, 6'd8, 1'b0, 1'b0, 1'b1, "R1 ror8");
        drive(32'h12345678, 32'h12345678, 2'b11, 6'd32, 1'b0, 1'b0, 1'b1, "R1 ror32");
        drive(32'h00000000, 32'hf0000000, 2'b10, 6'd5, 1'b0, 1'b0, 1'b1, "R1 asr5");
        drive(32'h80000001, 32'd2, 2'b00, 6'd3, 1'b1, 1'b1, 1'b1, "R2 rrx_c1");
        drive(32'h80000001, 32'd2, 2'b00, 6'd3, 1'b1, 1'b0, 1'b1, "R2 rrx_c0");
        drive(32'd100, 32'd3, 2'b00, 6'd3, 1'b0, 1'b0, 1'b1, "R6 cin0");
        drive(32'd100, 32'd3, 2'b00, 6'd3, 1'b0, 1'b1, 1'b1, "R6 cin1");
        drive(32'd1, 32'd9, 2'b00, 6'd0, 1'b0, 1'b0, 1'b0, "R9 hold1");
        drive(32'd9, 32'd9, 2'b00, 6'd0, 1'b0, 1'b0, 1'b0, "R9 hold2");
        drive(32'd0, 32'd0, 2'b01, 6'd0, 1'b0, 1'b0, 1'b1, "R5 zero");

        lfsr = 32'hace1_2468;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr, {lfsr[15:0], lfsr[31:16]} ^ 32'h5a5a0f0f, lfsr[3:2], lfsr[9:4],
                  lfsr[12] & lfsr[13], lfsr[14], lfsr[20] | lfsr[21], "R5_R7 mix");
        end

        @(negedge clk);
        cond = 1'b0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule